// File: doc/BRIEF.md
# SIMT Operand Collector Unit

This block sits in front of one execution unit. It keeps a small pool of collector entries, and each entry holds one in-flight operation. When the issue stage hands over a decoded warp instruction, the block stores it in a free entry: the opcode, the warp and lane tag, the lane mask and the number of source operands. In the same cycle it sends the source register identifiers to the register file as a read request. Register data then comes back tagged with an entry index and an operand slot index. The data can arrive in any order, spread over any number of cycles, and each value is latched into its own slot.

An entry is ready once every operand it needs is present. Each cycle the block offers one ready entry to the execution unit. It picks the oldest ready entry whose result would not land on the writeback port in the same cycle as a result already on its way. Ready entries go out regardless of sibling entries from the same warp that are still waiting. An operation with no source operands can bypass the pool and be offered in the cycle it is issued.

Back-pressure rules. On the issue side, `iss_ready` falls when every entry is occupied, and the issue stage holds its request until `iss_ready` rises again. On the dispatch side, a transfer happens in a cycle where both `dsp_valid` and `dsp_ready` are high. The offer is re-evaluated every cycle. While `dsp_ready` is low, `dsp_valid` and the payload may switch to a different ready entry, for example an older one or one that is no longer blocked at writeback. An offered entry that is not taken stays stored.

Top module: `opc_top`

## Requirements
- R1: After reset no entry is occupied: `iss_ready` is 1, `dsp_valid` is 0 and `rreq_valid` is 0.
- R2: An accepted issue (`iss_valid` and `iss_ready` both high) that is kept in the pool takes the lowest-numbered free entry. If `iss_nsrc` is not 0, then in that same cycle `rreq_valid` is 1, `rreq_ent` is the entry index, `rreq_cnt` equals `iss_nsrc` and `rreq_regs` equals `iss_src`.
- R3: A response with `rsp_valid` high writes `rsp_data` into slot `rsp_slot` of entry `rsp_ent`, whatever the order of the slots and the gaps between them. At dispatch, slot k of `dsp_opnd` (bits k*DATA_W and up) holds the data returned for slot k. Slots numbered `nsrc` or higher read 0.
- R4: An entry is offered only once all of its `nsrc` operands have been received. The earliest offer is in the cycle after the cycle in which the last operand was returned.
- R5: A ready entry is dispatched even while an older entry with the same tag is still waiting for operands.
- R6: Among ready entries that are not blocked at writeback, the entry allocated earliest is offered, whatever its index.
- R7: When all entries are occupied, `iss_ready` is 0, no read request is made, and a held request is accepted in the cycle after an entry frees.
- R8: An entry is freed in the cycle the execution unit accepts it, and an issue can take that index in the next cycle. While `dsp_ready` is low, a ready entry stays stored and stays offered.
- R9: An issue with `iss_nsrc` equal to 0, made while no stored entry is eligible, is offered in the same cycle with `dsp_ent` set to the lowest free index. If it is accepted in that cycle it occupies no entry.
- R10: The writeback latency is LAT_LONG (3) when the opcode's most significant bit is 1, and LAT_SHORT (1) otherwise. An operation whose writeback cycle would equal that of an operation already accepted is not offered until the clash is gone.
- R11: `dsp_op`, `dsp_tag` and `dsp_mask` equal the values issued with the dispatched operation, and `dsp_ent` names its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | A free entry exists |
| iss_op | input | OP_W | Opcode; MSB selects long latency |
| iss_tag | input | TAG_W | Warp and lane tag |
| iss_mask | input | LANES | Lane mask |
| iss_nsrc | input | clog2(NUM_SRC+1) | Number of source operands |
| iss_src | input | NUM_SRC*REG_W | Source register identifiers, slot k at k*REG_W |
| rreq_valid | output | 1 | Register read request |
| rreq_ent | output | clog2(NUM_ENT) | Entry the reads return to |
| rreq_cnt | output | clog2(NUM_SRC+1) | Number of registers to read |
| rreq_regs | output | NUM_SRC*REG_W | Registers to read |
| rsp_valid | input | 1 | Register data returning |
| rsp_ent | input | clog2(NUM_ENT) | Target entry |
| rsp_slot | input | clog2(NUM_SRC) | Target operand slot |
| rsp_data | input | DATA_W | Operand value |
| dsp_valid | output | 1 | Operation offered |
| dsp_ready | input | 1 | Execution unit accepts |
| dsp_ent | output | clog2(NUM_ENT) | Entry being offered |
| dsp_op | output | OP_W | Offered opcode |
| dsp_tag | output | TAG_W | Offered tag |
| dsp_mask | output | LANES | Offered lane mask |
| dsp_opnd | output | NUM_SRC*DATA_W | Offered operands, slot k at k*DATA_W |

## Verification
The assertions take it for granted that register data returns only to an occupied entry, only for a slot below that entry's operand count, and only once per slot. They also assume that no response targets an entry in the cycle it is allocated. The bench keeps to these rules by driving every response itself, one per cycle, always after the issue that created the entry and only for slots it has not yet returned. It sweeps every arrival order of one to three operands, with varying gaps between them.

// File: rtl/opc_pkg.sv
package opc_pkg;

  typedef enum logic {
    LAT_CLS_SHORT = 1'b0,
    LAT_CLS_LONG  = 1'b1
  } lat_cls_e;

  function automatic lat_cls_e op_class(input logic msb);
    return msb ? LAT_CLS_LONG : LAT_CLS_SHORT;
  endfunction

endpackage

// File: rtl/opc_entry.sv
module opc_entry #(
  parameter int NSRC  = 3,
  parameter int DW    = 32,
  parameter int OPW   = 6,
  parameter int TAGW  = 8,
  parameter int LANES = 16,
  parameter int AGEW  = 2,
  parameter int SLW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OPW-1:0]    a_op,
  input  logic [TAGW-1:0]   a_tag,
  input  logic [LANES-1:0]  a_mask,
  input  logic [NSRC-1:0]   a_need,
  input  logic              rsp_hit,
  input  logic [SLW-1:0]    rsp_slot,
  input  logic [DW-1:0]     rsp_data,
  input  logic              free_me,
  input  logic              other_alloc,
  input  logic              other_free,
  input  logic [AGEW-1:0]   free_age,
  output logic              vld,
  output logic              rdy,
  output logic [OPW-1:0]    op,
  output logic [TAGW-1:0]   tag,
  output logic [LANES-1:0]  mask,
  output logic [NSRC*DW-1:0] opnd,
  output logic [AGEW-1:0]   age
);

  logic [NSRC-1:0] need_q, got_q;
  logic [DW-1:0]   data_q [NSRC];
  logic [AGEW-1:0] age_n;

  // age counts the occupied entries allocated after this one
  always_comb begin
    age_n = age;
    if (other_alloc) age_n = age_n + AGEW'(1);
    if (other_free && (age > free_age)) age_n = age_n - AGEW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      need_q <= '0;
      got_q  <= '0;
      op     <= '0;
      tag    <= '0;
      mask   <= '0;
      age    <= '0;
      for (int k = 0; k < NSRC; k++) data_q[k] <= '0;
    end else if (alloc) begin
      vld    <= 1'b1;
      need_q <= a_need;
      got_q  <= '0;
      op     <= a_op;
      tag    <= a_tag;
      mask   <= a_mask;
      age    <= '0;
      for (int k = 0; k < NSRC; k++) data_q[k] <= '0;
    end else if (free_me) begin
      vld    <= 1'b0;
      need_q <= '0;
      got_q  <= '0;
    end else if (vld) begin
      age <= age_n;
      for (int k = 0; k < NSRC; k++) begin
        if (rsp_hit && (rsp_slot == SLW'(k))) begin
          got_q[k]  <= 1'b1;
          data_q[k] <= rsp_data;
        end
      end
    end
  end

  assign rdy = vld && ((got_q & need_q) == need_q);

  for (genvar k = 0; k < NSRC; k++) begin : g_opnd
    assign opnd[k*DW +: DW] = data_q[k];
  end

  // R3: a response lands only on an occupied entry and is remembered
  a_r3_hit_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> vld);
  a_r3_slot_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && vld && !free_me && !alloc) |=> got_q[$past(rsp_slot)]);
  // R8: acceptance frees the entry in the next state
  a_r8_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (free_me && !alloc) |=> !vld);

endmodule

// File: rtl/opc_pick.sv
module opc_pick #(
  parameter int NE   = 4,
  parameter int AGEW = 2,
  parameter int EW   = 2
) (
  input  logic [NE-1:0]           cand,
  input  logic [NE-1:0][AGEW-1:0] age,
  output logic                    any,
  output logic [EW-1:0]           idx
);

  logic [AGEW-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NE; i++) begin
      if (cand[i] && (!any || (age[i] > best))) begin
        any  = 1'b1;
        idx  = EW'(i);
        best = age[i];
      end
    end
  end

endmodule

// File: rtl/opc_wbres.sv
module opc_wbres #(
  parameter int MAXL = 3,
  parameter int LW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [LW-1:0] fire_lat,
  output logic [MAXL:0] busy
);

  logic [MAXL:0] tmp;

  // bit k set: a result reaches the writeback port k cycles from now
  always_comb begin
    tmp = busy;
    if (fire) tmp[fire_lat] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= tmp >> 1;
  end

  // R10: an accepted operation never claims an occupied writeback slot
  a_r10_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy[fire_lat]);

endmodule

// File: rtl/opc_top.sv
module opc_top
  import opc_pkg::*;
#(
  parameter int NUM_ENT   = 4,
  parameter int NUM_SRC   = 3,
  parameter int DATA_W    = 32,
  parameter int OP_W      = 6,
  parameter int TAG_W     = 8,
  parameter int LANES     = 16,
  parameter int REG_W     = 6,
  parameter int LAT_SHORT = 1,
  parameter int LAT_LONG  = 3,
  localparam int EW   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int SLW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNTW = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  output logic                      iss_ready,
  input  logic [OP_W-1:0]           iss_op,
  input  logic [TAG_W-1:0]          iss_tag,
  input  logic [LANES-1:0]          iss_mask,
  input  logic [CNTW-1:0]           iss_nsrc,
  input  logic [NUM_SRC*REG_W-1:0]  iss_src,
  output logic                      rreq_valid,
  output logic [EW-1:0]             rreq_ent,
  output logic [CNTW-1:0]           rreq_cnt,
  output logic [NUM_SRC*REG_W-1:0]  rreq_regs,
  input  logic                      rsp_valid,
  input  logic [EW-1:0]             rsp_ent,
  input  logic [SLW-1:0]            rsp_slot,
  input  logic [DATA_W-1:0]         rsp_data,
  output logic                      dsp_valid,
  input  logic                      dsp_ready,
  output logic [EW-1:0]             dsp_ent,
  output logic [OP_W-1:0]           dsp_op,
  output logic [TAG_W-1:0]          dsp_tag,
  output logic [LANES-1:0]          dsp_mask,
  output logic [NUM_SRC*DATA_W-1:0] dsp_opnd
);

  localparam int AGEW = EW;
  localparam int MAXL = (LAT_LONG > LAT_SHORT) ? LAT_LONG : LAT_SHORT;
  localparam int LW   = $clog2(MAXL + 1);

  logic [NUM_ENT-1:0]                     ent_vld, ent_rdy, cand;
  logic [NUM_ENT-1:0][OP_W-1:0]           ent_op;
  logic [NUM_ENT-1:0][TAG_W-1:0]          ent_tag;
  logic [NUM_ENT-1:0][LANES-1:0]          ent_mask;
  logic [NUM_ENT-1:0][NUM_SRC*DATA_W-1:0] ent_opnd;
  logic [NUM_ENT-1:0][AGEW-1:0]           ent_age;
  logic [NUM_ENT-1:0][LW-1:0]             ent_lat;

  logic [EW-1:0]      free_idx, st_idx;
  logic               st_any, byp_ok, fire, st_fire, byp_fire, iss_fire, alloc_store;
  logic [NUM_SRC-1:0] iss_need;
  logic [LW-1:0]      iss_lat, dsp_lat;
  logic [MAXL:0]      busy;

  function automatic logic [LW-1:0] lat_of(input logic [OP_W-1:0] o);
    return (op_class(o[OP_W-1]) == LAT_CLS_LONG) ? LW'(LAT_LONG) : LW'(LAT_SHORT);
  endfunction

  // lowest-numbered free entry
  always_comb begin
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = EW'(i);
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) iss_need[k] = (CNTW'(k) < iss_nsrc);
  end

  assign iss_ready = ~&ent_vld;
  assign iss_fire  = iss_valid && iss_ready;
  assign iss_lat   = lat_of(iss_op);

  assign rreq_valid = iss_fire && (iss_nsrc != '0);
  assign rreq_ent   = free_idx;
  assign rreq_cnt   = iss_nsrc;
  assign rreq_regs  = iss_src;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic alloc_g, free_g;
    assign alloc_g = alloc_store && (free_idx == EW'(g));
    assign free_g  = st_fire && (st_idx == EW'(g));

    opc_entry #(
      .NSRC(NUM_SRC), .DW(DATA_W), .OPW(OP_W), .TAGW(TAG_W),
      .LANES(LANES), .AGEW(AGEW), .SLW(SLW)
    ) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_g),
      .a_op       (iss_op),
      .a_tag      (iss_tag),
      .a_mask     (iss_mask),
      .a_need     (iss_need),
      .rsp_hit    (rsp_valid && (rsp_ent == EW'(g))),
      .rsp_slot   (rsp_slot),
      .rsp_data   (rsp_data),
      .free_me    (free_g),
      .other_alloc(alloc_store && !alloc_g),
      .other_free (st_fire && !free_g),
      .free_age   (ent_age[st_idx]),
      .vld        (ent_vld[g]),
      .rdy        (ent_rdy[g]),
      .op         (ent_op[g]),
      .tag        (ent_tag[g]),
      .mask       (ent_mask[g]),
      .opnd       (ent_opnd[g]),
      .age        (ent_age[g])
    );

    assign ent_lat[g] = lat_of(ent_op[g]);
    assign cand[g]    = ent_rdy[g] && !busy[ent_lat[g]];
  end

  opc_pick #(.NE(NUM_ENT), .AGEW(AGEW), .EW(EW)) u_pick (
    .cand(cand),
    .age (ent_age),
    .any (st_any),
    .idx (st_idx)
  );

  // zero-operand bypass straight from the issue port
  assign byp_ok    = iss_fire && (iss_nsrc == '0) && !busy[iss_lat] && !st_any;
  assign dsp_valid = st_any || byp_ok;
  assign fire      = dsp_valid && dsp_ready;
  assign st_fire   = fire && st_any;
  assign byp_fire  = fire && !st_any;
  assign alloc_store = iss_fire && !byp_fire;

  always_comb begin
    if (st_any) begin
      dsp_ent  = st_idx;
      dsp_op   = ent_op[st_idx];
      dsp_tag  = ent_tag[st_idx];
      dsp_mask = ent_mask[st_idx];
      dsp_opnd = ent_opnd[st_idx];
    end else begin
      dsp_ent  = free_idx;
      dsp_op   = iss_op;
      dsp_tag  = iss_tag;
      dsp_mask = iss_mask;
      dsp_opnd = '0;
    end
  end
  assign dsp_lat = lat_of(dsp_op);

  opc_wbres #(.MAXL(MAXL), .LW(LW)) u_wb (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .fire_lat(dsp_lat),
    .busy    (busy)
  );

  // R7: a full pool issues no read request
  a_r7_full_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |-> !rreq_valid);
  // R2: allocation targets an unoccupied entry
  a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_store |-> !ent_vld[free_idx]);
  // R4: a stored entry is offered only when it holds all operands
  a_r4_offer_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && st_any) |-> ent_rdy[dsp_ent]);
  // R8: an accepted stored entry is gone the next cycle
  a_r8_gone_after: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> !ent_vld[$past(st_idx)]);
  // R10: offered operation never clashes at writeback
  a_r10_offer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> !busy[dsp_lat]);

endmodule

// File: tb/opc_top_tb_top.sv
module opc_top_tb_top;

  localparam int NE = 4, NS = 3, DW = 32, OPW = 6, TW = 8, LN = 16, RW = 6;
  localparam int EW = 2, SLW = 2, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 0, iss_ready, rreq_valid, rsp_valid = 0, dsp_valid, dsp_ready = 0;
  logic [OPW-1:0] iss_op = 0, dsp_op;
  logic [TW-1:0]  iss_tag = 0, dsp_tag;
  logic [LN-1:0]  iss_mask = 0, dsp_mask;
  logic [CW-1:0]  iss_nsrc = 0, rreq_cnt;
  logic [NS*RW-1:0] iss_src = 0, rreq_regs;
  logic [EW-1:0]  rreq_ent, rsp_ent = 0, dsp_ent;
  logic [SLW-1:0] rsp_slot = 0;
  logic [DW-1:0]  rsp_data = 0;
  logic [NS*DW-1:0] dsp_opnd;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  opc_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_tag(iss_tag),
    .iss_mask(iss_mask), .iss_nsrc(iss_nsrc), .iss_src(iss_src),
    .rreq_valid(rreq_valid), .rreq_ent(rreq_ent), .rreq_cnt(rreq_cnt), .rreq_regs(rreq_regs),
    .rsp_valid(rsp_valid), .rsp_ent(rsp_ent), .rsp_slot(rsp_slot), .rsp_data(rsp_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_ent(dsp_ent), .dsp_op(dsp_op),
    .dsp_tag(dsp_tag), .dsp_mask(dsp_mask), .dsp_opnd(dsp_opnd)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [OPW-1:0] op, input logic [TW-1:0] tg, input logic [LN-1:0] mk,
                       input int n, input int rbase, output int ent);
    iss_valid = 1; iss_op = op; iss_tag = tg; iss_mask = mk; iss_nsrc = CW'(n);
    for (int k = 0; k < NS; k++) iss_src[k*RW +: RW] = RW'(rbase + k);
    #1;
    chk(iss_ready == 1, "R2 iss_ready", iss_ready, 1);
    chk(rreq_valid == (n != 0), "R2 rreq_valid", rreq_valid, n != 0);
    if (n != 0) begin
      chk(rreq_cnt == CW'(n), "R2 rreq_cnt", rreq_cnt, n);
      chk(rreq_regs == iss_src, "R2 rreq_regs", rreq_regs, iss_src);
    end
    ent = int'(rreq_ent);
    cyc();
    iss_valid = 0;
  endtask

  task automatic rsp(input int e, input int s, input logic [DW-1:0] d);
    rsp_valid = 1; rsp_ent = EW'(e); rsp_slot = SLW'(s); rsp_data = d;
    cyc();
    rsp_valid = 0;
  endtask

  task automatic take(input int e, input string req);
    #1;
    chk(dsp_valid == 1, req, dsp_valid, 1);
    chk(int'(dsp_ent) == e, req, dsp_ent, e);
    dsp_ready = 1;
    cyc();
    dsp_ready = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired before the run ended");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int e, e0, e1, e2, e3;
    int d [3];
    int n, m;
    logic [DW-1:0] val;
    repeat (3) cyc();
    rst_n = 1;
    #1;
    chk(iss_ready == 1, "R1 iss_ready", iss_ready, 1);
    chk(dsp_valid == 0, "R1 dsp_valid", dsp_valid, 0);
    chk(rreq_valid == 0, "R1 rreq_valid", rreq_valid, 0);
    cyc();

    // R3/R4 sweep over operand counts and every arrival order
    for (int nn = 1; nn <= NS; nn++) begin
      for (int code = 0; code < 27; code++) begin
        bit ok;
        n = nn;
        d[0] = code % 3; d[1] = (code / 3) % 3; d[2] = code / 9;
        ok = 1;
        for (int a = 0; a < 3; a++) begin
          if (a >= n && d[a] != 0) ok = 0;
          if (a < n && d[a] >= n) ok = 0;
          for (int b = 0; b < a; b++) if (a < n && d[a] == d[b]) ok = 0;
        end
        if (!ok) continue;
        issue(OPW'(code & 31), TW'(code + 16 * n), LN'(16'h1 << code[3:0]), n, code, e);
        chk(e == 0, "R2 lowest entry", e, 0);
        for (int p = 0; p < n; p++) begin
          rsp_valid = 1; rsp_ent = 0; rsp_slot = SLW'(d[p]);
          rsp_data = 32'hA000_0000 + DW'(code * 256 + d[p] * 16 + n);
          #1;
          chk(dsp_valid == 0, "R4 not ready early", dsp_valid, 0);
          cyc();
          rsp_valid = 0;
          if (p < n - 1) begin
            for (int g = 0; g < code % 2; g++) begin
              #1; chk(dsp_valid == 0, "R4 waiting gap", dsp_valid, 0);
              cyc();
            end
          end
        end
        #1;
        chk(dsp_valid == 1, "R4 ready after last", dsp_valid, 1);
        for (int k = 0; k < NS; k++) begin
          val = (k < n) ? 32'hA000_0000 + DW'(code * 256 + k * 16 + n) : '0;
          chk(dsp_opnd[k*DW +: DW] == val, "R3 operand slot", dsp_opnd[k*DW +: DW], val);
        end
        chk(dsp_op == OPW'(code & 31), "R11 op", dsp_op, code & 31);
        chk(dsp_tag == TW'(code + 16 * n), "R11 tag", dsp_tag, code + 16 * n);
        chk(dsp_mask == LN'(16'h1 << code[3:0]), "R11 mask", dsp_mask, 16'h1 << code[3:0]);
        dsp_ready = 1; cyc(); dsp_ready = 0;
        #1;
        chk(dsp_valid == 0, "R8 freed on accept", dsp_valid, 0);
        cyc();
      end
    end

    // R5: younger entry of the same warp overtakes a waiting one
    issue(6'h03, 8'h55, 16'hFFFF, 3, 10, e0);
    issue(6'h04, 8'h55, 16'h00FF, 1, 20, e1);
    chk(e1 == 1, "R2 second entry", e1, 1);
    rsp(e1, 0, 32'h1111);
    #1;
    chk(dsp_op == 6'h04, "R5 younger dispatched", dsp_op, 6'h04);
    take(1, "R5 out of order");
    rsp(e0, 2, 32'h22); rsp(e0, 0, 32'h20); rsp(e0, 1, 32'h21);
    take(0, "R5 older later");

    // R6 and R8: age decides, not index
    issue(6'h01, 8'h01, 16'h1, 1, 0, e0);
    issue(6'h02, 8'h02, 16'h2, 1, 0, e1);
    rsp(e0, 0, 32'h5);
    take(0, "R8 first out");
    issue(6'h05, 8'h05, 16'h5, 1, 0, e2);
    chk(e2 == 0, "R8 index reused", e2, 0);
    rsp(e2, 0, 32'h6); rsp(e1, 0, 32'h7);
    #1;
    chk(dsp_ent == 1, "R6 oldest first", dsp_ent, 1);
    cyc();
    #1;
    chk(dsp_valid == 1 && dsp_ent == 1, "R8 held while not ready", dsp_ent, 1);
    take(1, "R6 oldest taken");
    take(0, "R6 younger next");

    // R7: full pool holds the issue
    issue(6'h01, 8'h10, 16'h1, 1, 0, e0);
    issue(6'h01, 8'h11, 16'h1, 1, 0, e1);
    issue(6'h01, 8'h12, 16'h1, 1, 0, e2);
    issue(6'h01, 8'h13, 16'h1, 1, 0, e3);
    chk(e3 == 3, "R2 fourth entry", e3, 3);
    iss_valid = 1; iss_nsrc = 1; iss_tag = 8'h14;
    for (int w = 0; w < 2; w++) begin
      #1;
      chk(iss_ready == 0, "R7 full", iss_ready, 0);
      chk(rreq_valid == 0, "R7 no read", rreq_valid, 0);
      cyc();
    end
    rsp_valid = 1; rsp_ent = 2; rsp_slot = 0; rsp_data = 32'h9;
    cyc(); rsp_valid = 0;
    #1;
    chk(iss_ready == 0, "R7 still full", iss_ready, 0);
    dsp_ready = 1; cyc(); dsp_ready = 0;
    #1;
    chk(iss_ready == 1 && rreq_valid == 1, "R7 held issue accepted", {iss_ready, rreq_valid}, 3);
    chk(rreq_ent == 2, "R8 freed index", rreq_ent, 2);
    cyc(); iss_valid = 0;
    rsp(0, 0, 1); rsp(1, 0, 1); rsp(3, 0, 1); rsp(2, 0, 1);
    take(0, "R6 drain 0"); take(1, "R6 drain 1"); take(3, "R6 drain 3"); take(2, "R6 drain 2");

    // R9: zero-operand bypass accepted consumes no entry
    iss_valid = 1; iss_op = 6'h07; iss_nsrc = 0; iss_tag = 8'h77; dsp_ready = 1;
    #1;
    chk(dsp_valid == 1 && dsp_ent == 0 && dsp_tag == 8'h77, "R9 same cycle", dsp_valid, 1);
    cyc(); iss_valid = 0; dsp_ready = 0;
    issue(6'h01, 8'h01, 16'h1, 1, 0, e);
    chk(e == 0, "R9 no entry used", e, 0);
    rsp(0, 0, 1);
    take(0, "R9 cleanup");

    // R9/R8: bypass not accepted is stored and offered
    iss_valid = 1; iss_op = 6'h08; iss_nsrc = 0;
    #1;
    chk(dsp_valid == 1, "R9 offered", dsp_valid, 1);
    cyc(); iss_valid = 0;
    #1;
    chk(dsp_valid == 1 && dsp_op == 6'h08, "R8 stored after refusal", dsp_op, 6'h08);
    take(0, "R8 stored taken");

    // R10: long op then short ops
    iss_valid = 1; iss_op = 6'h21; iss_nsrc = 0; dsp_ready = 1;
    #1; chk(dsp_valid == 1, "R10 long offered", dsp_valid, 1);
    cyc();
    iss_op = 6'h02;
    #1; chk(dsp_valid == 1, "R10 short no clash", dsp_valid, 1);
    cyc();
    iss_op = 6'h03;
    #1; chk(dsp_valid == 0, "R10 clash blocked", dsp_valid, 0);
    cyc(); iss_valid = 0;
    #1; chk(dsp_valid == 1 && dsp_op == 6'h03 && dsp_ent == 0, "R10 after clash", dsp_op, 6'h03);
    cyc(); dsp_ready = 0;
    #1; chk(dsp_valid == 0 && iss_ready == 1, "R10 drained", dsp_valid, 0);

    m = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + m);
    $finish;
  end

endmodule